// File: doc/BRIEF.md
# Deblocking Edge Scan Sequencer

This block drives the per-macroblock scan of a deblocking filter core. A start pulse launches one pass over a 16x16 luma macroblock and its chroma lines. The scan covers the four vertical 4x4 block edges from left to right, then the four horizontal edges from top to bottom. For each edge it steps through 16 luma lines and then 8 chroma lines. It advances at most one step per clock cycle, which matches a pixel store with a single port.

At each step the sequencer presents an address into a 32-entry boundary-strength store and reads back a 2-bit filter class in the same cycle. When the class selects a filter, the step becomes a command on a valid/ready output. The command carries the direction, edge, plane, line and filter type. When the class selects no filter, the step is skipped silently, and the skip still takes one cycle. A one-cycle done pulse marks the end of the pass.

Top module: `dbk_edge_seq`

## Requirements
- R1: While rst_ni is low and after it is released, done_o and cmd_valid_o are 0. The block stays idle until start_i is sampled high.
- R2: start_i sampled high while idle starts a scan. The first step is direction 0, edge 0, luma, line 0. cmd_valid_o is 0 whenever no scan is running.
- R3: Steps follow a fixed order. Vertical edges (cmd_dir_o=0) come before horizontal edges (1), and edges run 0 to 3. Within each edge, luma lines 0..15 (cmd_chroma_o=0) come first, then chroma lines 0..7 (cmd_chroma_o=1).
- R4: bs_addr_o = dir*16 + edge*4 + blk. Here blk is line/4 for luma and line/2 for chroma. bs_class_i is used in the same cycle.
- R5: Class 01 (standard) and class 10 (strong) raise cmd_valid_o, and cmd_ftype_o equals the class. Class 00 and class 11 emit nothing. Every step, emitted or skipped, lasts one cycle unless it is stalled.
- R6: While cmd_valid_o is high and cmd_ready_i is low, the step and all command fields hold.
- R7: done_o is high for exactly one cycle, in the cycle after the last chroma line of horizontal edge 3 completes. With no stalls this is 192 cycles after the start edge.
- R8: start_i sampled high during a scan has no effect on the command sequence or on its timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start a macroblock scan |
| done_o | output | 1 | One-cycle end-of-scan pulse |
| bs_addr_o | output | 5 | Boundary-strength store address |
| bs_class_i | input | 2 | Filter class read for bs_addr_o |
| cmd_valid_o | output | 1 | Command valid |
| cmd_ready_i | input | 1 | Command accepted by the datapath |
| cmd_dir_o | output | 1 | 0 vertical edge, 1 horizontal edge |
| cmd_edge_o | output | 2 | Edge index 0..3 |
| cmd_chroma_o | output | 1 | 0 luma line, 1 chroma line |
| cmd_line_o | output | 4 | Line index along the edge |
| cmd_ftype_o | output | 2 | 01 standard, 10 strong |

## Verification
A fault in a counter shows up at the first command after the faulty step. In that cycle the line, edge or plane field is wrong, and the store address no longer matches the expected block. A wrong skip or stall decision does not always corrupt a field. It does move done_o away from 192 cycles plus the stall count, so every scan is timed from start to done. A scan that is re-entered or cut short changes either the number of commands or the done timing.

// File: rtl/dbk_seq_pkg.sv
package dbk_seq_pkg;
  typedef enum logic [1:0] {
    FT_NONE   = 2'b00,
    FT_STD    = 2'b01,
    FT_STRONG = 2'b10,
    FT_RSVD   = 2'b11
  } ftype_e;

  function automatic logic ftype_active(input logic [1:0] c);
    return (c == FT_STD) || (c == FT_STRONG);
  endfunction
endpackage

// File: rtl/dbk_scan_ctr.sv
module dbk_scan_ctr #(
  parameter int EDGES        = 4,
  parameter int LUMA_LINES   = 16,
  parameter int CHROMA_LINES = 8,
  localparam int EW = $clog2(EDGES),
  localparam int LW = $clog2(LUMA_LINES)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic          adv_i,
  output logic          dir_o,
  output logic [EW-1:0] edge_o,
  output logic          chroma_o,
  output logic [LW-1:0] line_o,
  output logic          last_o
);
  localparam logic [EW-1:0] EDGE_MAX = EW'(EDGES - 1);
  localparam logic [LW-1:0] LUMA_MAX = LW'(LUMA_LINES - 1);
  localparam logic [LW-1:0] CHR_MAX  = LW'(CHROMA_LINES - 1);

  logic          dir_q;
  logic [EW-1:0] edge_q;
  logic          chroma_q;
  logic [LW-1:0] line_q;

  // all counters count down; outputs are ascending indices
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dir_q    <= 1'b1;
      edge_q   <= EDGE_MAX;
      chroma_q <= 1'b0;
      line_q   <= LUMA_MAX;
    end else if (load_i) begin
      dir_q    <= 1'b1;
      edge_q   <= EDGE_MAX;
      chroma_q <= 1'b0;
      line_q   <= LUMA_MAX;
    end else if (adv_i) begin
      if (line_q != '0) begin
        line_q <= line_q - 1'b1;
      end else if (!chroma_q) begin
        chroma_q <= 1'b1;
        line_q   <= CHR_MAX;
      end else begin
        chroma_q <= 1'b0;
        line_q   <= LUMA_MAX;
        if (edge_q != '0) begin
          edge_q <= edge_q - 1'b1;
        end else begin
          edge_q <= EDGE_MAX;
          dir_q  <= ~dir_q;
        end
      end
    end
  end

  assign dir_o    = ~dir_q;
  assign edge_o   = EDGE_MAX - edge_q;
  assign chroma_o = chroma_q;
  assign line_o   = (chroma_q ? CHR_MAX : LUMA_MAX) - line_q;
  assign last_o   = !dir_q && (edge_q == '0) && chroma_q && (line_q == '0);
endmodule

// File: rtl/dbk_bs_addr.sv
module dbk_bs_addr #(
  parameter int EDGES        = 4,
  parameter int LUMA_LINES   = 16,
  parameter int CHROMA_LINES = 8,
  localparam int EW  = $clog2(EDGES),
  localparam int LW  = $clog2(LUMA_LINES),
  localparam int AW  = 1 + 2 * EW,
  localparam int LSH = $clog2(LUMA_LINES / EDGES),
  localparam int CSH = $clog2(CHROMA_LINES / EDGES)
) (
  input  logic          dir_i,
  input  logic [EW-1:0] edge_i,
  input  logic          chroma_i,
  input  logic [LW-1:0] line_i,
  output logic [AW-1:0] addr_o
);
  logic [LW-1:0] blk_full;
  logic [EW-1:0] blk;

  assign blk_full = chroma_i ? (line_i >> CSH) : (line_i >> LSH);
  assign blk      = blk_full[EW-1:0];
  assign addr_o   = {dir_i, edge_i, blk};
endmodule

// File: rtl/dbk_cmd_gate.sv
module dbk_cmd_gate
  import dbk_seq_pkg::*;
(
  input  logic       busy_i,
  input  logic [1:0] class_i,
  input  logic       ready_i,
  output logic       valid_o,
  output logic [1:0] ftype_o,
  output logic       adv_o
);
  logic active;

  assign active  = ftype_active(class_i);
  assign valid_o = busy_i && active;
  assign ftype_o = active ? class_i : FT_NONE;
  // skipped steps advance unconditionally
  assign adv_o   = busy_i && (!active || ready_i);
endmodule

// File: rtl/dbk_edge_seq.sv
module dbk_edge_seq #(
  parameter int EDGES        = 4,
  parameter int LUMA_LINES   = 16,
  parameter int CHROMA_LINES = 8,
  localparam int EW = $clog2(EDGES),
  localparam int LW = $clog2(LUMA_LINES),
  localparam int AW = 1 + 2 * EW
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  output logic          done_o,
  output logic [AW-1:0] bs_addr_o,
  input  logic [1:0]    bs_class_i,
  output logic          cmd_valid_o,
  input  logic          cmd_ready_i,
  output logic          cmd_dir_o,
  output logic [EW-1:0] cmd_edge_o,
  output logic          cmd_chroma_o,
  output logic [LW-1:0] cmd_line_o,
  output logic [1:0]    cmd_ftype_o
);
  logic busy_q, done_q;
  logic load, adv, last;

  assign load = start_i && !busy_q;

  dbk_scan_ctr #(
    .EDGES(EDGES), .LUMA_LINES(LUMA_LINES), .CHROMA_LINES(CHROMA_LINES)
  ) u_ctr (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (load),
    .adv_i    (adv),
    .dir_o    (cmd_dir_o),
    .edge_o   (cmd_edge_o),
    .chroma_o (cmd_chroma_o),
    .line_o   (cmd_line_o),
    .last_o   (last)
  );

  dbk_bs_addr #(
    .EDGES(EDGES), .LUMA_LINES(LUMA_LINES), .CHROMA_LINES(CHROMA_LINES)
  ) u_addr (
    .dir_i    (cmd_dir_o),
    .edge_i   (cmd_edge_o),
    .chroma_i (cmd_chroma_o),
    .line_i   (cmd_line_o),
    .addr_o   (bs_addr_o)
  );

  dbk_cmd_gate u_gate (
    .busy_i  (busy_q),
    .class_i (bs_class_i),
    .ready_i (cmd_ready_i),
    .valid_o (cmd_valid_o),
    .ftype_o (cmd_ftype_o),
    .adv_o   (adv)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= adv && last;
      if (load)             busy_q <= 1'b1;
      else if (adv && last) busy_q <= 1'b0;
    end
  end

  assign done_o = done_q;
endmodule

// File: rtl/dbk_edge_seq_chk.sv
module dbk_edge_seq_chk #(
  parameter int LW = 4,
  parameter int AW = 5,
  parameter int CHROMA_LINES = 8
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          start_i,
  input logic          done_o,
  input logic          busy_q,
  input logic          cmd_valid_o,
  input logic          cmd_ready_i,
  input logic [1:0]    cmd_ftype_o,
  input logic          cmd_chroma_o,
  input logic [LW-1:0] cmd_line_o,
  input logic [AW-1:0] bs_addr_o
);
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R7
  AST_DONE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !cmd_valid_o); // R7
  AST_IDLE_SILENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_q |-> !cmd_valid_o); // R2
  AST_FTYPE_LEGAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o |-> (cmd_ftype_o == 2'b01 || cmd_ftype_o == 2'b10)); // R5
  AST_STALL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_o && !cmd_ready_i) |=>
      ($stable(bs_addr_o) && $stable(cmd_line_o) && $stable(cmd_chroma_o))); // R6
  AST_CHROMA_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_o && cmd_chroma_o) |-> (int'(cmd_line_o) < CHROMA_LINES)); // R3
  AST_START_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && start_i) |=> (busy_q || done_o)); // R8
endmodule

bind dbk_edge_seq dbk_edge_seq_chk #(.LW(LW), .AW(AW), .CHROMA_LINES(CHROMA_LINES)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .start_i      (start_i),
  .done_o       (done_o),
  .busy_q       (busy_q),
  .cmd_valid_o  (cmd_valid_o),
  .cmd_ready_i  (cmd_ready_i),
  .cmd_ftype_o  (cmd_ftype_o),
  .cmd_chroma_o (cmd_chroma_o),
  .cmd_line_o   (cmd_line_o),
  .bs_addr_o    (bs_addr_o)
);

// File: tb/dbk_edge_seq_tb.sv
module dbk_edge_seq_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic       ready = 1'b1;
  logic       done;
  logic [4:0] bs_addr;
  logic [1:0] bs_class;
  logic       cmd_valid, cmd_dir, cmd_chroma;
  logic [1:0] cmd_edge, cmd_ftype;
  logic [3:0] cmd_line;

  logic [1:0] store [32];
  assign bs_class = store[bs_addr];

  int checks = 0;
  int fails  = 0;

  // {fill[7:4], unused[3:2], stall[1], inject_start[0]}
  localparam logic [7:0] VECS [6] = '{8'h00, 8'h12, 8'h20, 8'h33, 8'h41, 8'h30};

  // packed command: dir,edge,chroma,line,ftype,addr
  logic [14:0] exp_q [192];
  int exp_n;

  always #10 clk = ~clk;

  dbk_edge_seq u_dut (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .start_i      (start),
    .done_o       (done),
    .bs_addr_o    (bs_addr),
    .bs_class_i   (bs_class),
    .cmd_valid_o  (cmd_valid),
    .cmd_ready_i  (ready),
    .cmd_dir_o    (cmd_dir),
    .cmd_edge_o   (cmd_edge),
    .cmd_chroma_o (cmd_chroma),
    .cmd_line_o   (cmd_line),
    .cmd_ftype_o  (cmd_ftype)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [1:0] fill_class(input int f, input int a);
    case (f)
      0: return 2'b00;
      1: return 2'b01;
      2: return 2'b10;
      3: return 2'((a & 3) ^ ((a >> 2) & 3));
      default: return (a >= 16) ? 2'b10 : 2'b11;
    endcase
  endfunction

  task automatic prepare(input int f);
    for (int a = 0; a < 32; a++) store[a] = fill_class(f, a);
    exp_n = 0;
    for (int d = 0; d < 2; d++)
      for (int e = 0; e < 4; e++)
        for (int c = 0; c < 2; c++)
          for (int l = 0; l < (c ? 8 : 16); l++) begin
            int blk = c ? l / 2 : l / 4;
            int a = d * 16 + e * 4 + blk;
            logic [1:0] k = store[a];
            if (k == 2'b01 || k == 2'b10) begin
              exp_q[exp_n] = {1'(d), 2'(e), 1'(c), 4'(l), k, 5'(a)};
              exp_n++;
            end
          end
  endtask

  task automatic run_scan(input logic [7:0] v);
    int idx = 0, stalls = 0, it = 0;
    bit done_seen = 0;
    bit stall = v[1];
    bit inj = v[0];
    prepare(int'(v[7:4]));
    @(negedge clk) start = 1'b1;
    while (!done_seen && it < 2000) begin
      @(negedge clk);
      it++;
      start = inj && (it == 50);  // R8: start during a scan
      ready = stall ? ((it % 3) != 0) : 1'b1;
      #1;
      if (done) done_seen = 1;
      else if (cmd_valid) begin
        logic [14:0] act = {cmd_dir, cmd_edge, cmd_chroma, cmd_line, cmd_ftype, bs_addr};
        logic [14:0] ex = (idx < exp_n) ? exp_q[idx] : '1;
        chk(act[14:7] == ex[14:7], "R3 order", int'(act[14:7]), int'(ex[14:7]));
        chk(act[4:0] == ex[4:0], "R4 addr", int'(act[4:0]), int'(ex[4:0]));
        chk(act[6:5] == ex[6:5], "R5 ftype", int'(act[6:5]), int'(ex[6:5]));
        if (!ready) stalls++;  // R6: same command expected next cycle
        else idx++;
      end
    end
    start = 1'b0;
    ready = 1'b1;
    chk(done_seen, "R7 done seen", int'(done_seen), 1);
    chk(idx == exp_n, "R3 command count", idx, exp_n);
    chk(it - 1 == 192 + stalls, "R5/R7 scan cycles", it - 1, 192 + stalls);
    @(negedge clk); #1;
    chk(!done, "R7 single pulse", int'(done), 0);
    chk(!cmd_valid, "R2 idle after scan", int'(cmd_valid), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    prepare(1);
    #5;
    chk(!done && !cmd_valid, "R1 in reset", int'(done) + int'(cmd_valid), 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    #1;
    chk(!done && !cmd_valid, "R1 idle after reset", int'(done) + int'(cmd_valid), 0);

    foreach (VECS[i]) run_scan(VECS[i]);

    // R1: reset in the middle of a scan returns to idle
    prepare(1);
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    repeat (20) @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk(!cmd_valid && !done, "R1 async reset", int'(cmd_valid), 0);
    @(negedge clk) rst_n = 1'b1;
    repeat (5) begin
      @(negedge clk); #1;
      chk(!cmd_valid && !done, "R1 idle after mid-scan reset", int'(cmd_valid), 0);
    end
    run_scan(8'h10);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule